// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block controls how a simple processor core enters and leaves device interrupt handlers. At the start of each fetch-execute iteration, the core raises a fetch request. The sequencer checks the device-interrupt flag in that same cycle, before it allows the fetch. If the flag is set and no handler is already running, the sequencer holds the fetch off and runs a two-cycle entry sequence:

- The link register (r6) is pushed onto a memory stack addressed by the stack pointer (r5).
- The current PC is moved into the link register.
- A handler address is read from a jump table in memory. The sequencer loads it into the PC.

The table entry is found from a programmable vector base plus the ID of the interrupting controller.

When the core decodes a return-from-interrupt instruction, it pulses a return request. In one cycle, the sequencer then:

- sends the PC back to the old link value,
- reloads the link register from the stack,
- pops the stack pointer,
- pulses a clear to the device-interrupt flag.

The core's register file and memory stay outside the block. The sequencer only presents write strobes and values for r5, r6 and the PC, and drives a single memory port whose read data returns in the same cycle.

Top module: `irq_vec_seq`

## Requirements
- R1: After reset no handler is active, no register or memory strobe is asserted, and `fetch_go` equals `fetch_req` while no interrupt is pending.
- R2: An interrupt is taken in an idle cycle in which `fetch_req` is high, `rti_req` is low, `irq_flag` is high and no handler is active; in that cycle `fetch_go` is low.
- R3: In the first cycle after the interrupt is taken, the block writes the old r6 to memory at address r5−4, and writes r5−4 back to r5.
- R4: In that same first entry cycle, r6 receives the current PC.
- R5: In the second entry cycle, the block reads memory at vector base + 4 × ID and writes the word it reads into the PC. Handler mode becomes active after that cycle.
- R6: While handler mode is active, a pending interrupt is not taken, and `fetch_go` follows `fetch_req`.
- R7: A cycle with `rti_req` high in the idle state does all of the following: sets the PC to the r6 value held before that cycle; reloads r6 from memory at r5; sets r5 to r5+4; pulses `irq_clear`; and leaves handler mode after the cycle. `fetch_go` is low in that cycle.
- R8: A write on `vbase_we` loads the vector base. Every later entry indexes its table from the new base.
- R9: `fetch_go` stays low in both entry cycles, and fetch resumes in the cycle after the second entry cycle.
- R10: The controller ID is captured in the cycle in which the interrupt is taken. A change on `irq_id` during the entry cycles does not alter the table address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_req | input | 1 | Core wants to start a fetch-execute iteration |
| rti_req | input | 1 | Core decoded a return-from-interrupt (one-cycle pulse) |
| irq_flag | input | 1 | Device-interrupt flag |
| irq_id | input | IDW | ID of the interrupting controller |
| vbase_we | input | 1 | Load the vector base register |
| vbase_wdata | input | DW | New vector base |
| pc_cur | input | DW | Current PC |
| sp_cur | input | DW | Current r5 (stack pointer) |
| lr_cur | input | DW | Current r6 (link register) |
| fetch_go | output | 1 | Fetch may proceed this cycle |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | DW | New PC |
| sp_we | output | 1 | r5 write strobe |
| sp_wdata | output | DW | New r5 |
| lr_we | output | 1 | r6 write strobe |
| lr_wdata | output | DW | New r6 |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | DW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the same cycle |
| irq_clear | output | 1 | Clears the device-interrupt flag |
| in_handler | output | 1 | A handler is running |

## Verification
The assertions assume that the core applies every strobe at the next clock edge. They also assume that the core holds `pc_cur`, `sp_cur` and `lr_cur` steady apart from those writes, and that the memory returns read data within the same cycle.

They further assume that `rti_req` is a single-cycle pulse that arrives only while the core is not fetching.

The bench plays the part of that core. It updates its own r5, r6, PC and a small word memory only from the block's strobes. It pulses the return request for exactly one cycle, with the fetch request low. It changes `irq_id` only to test that the ID is captured at entry.

// File: rtl/irq_vec_seq.sv
module irq_vec_seq #(
  parameter int DW  = 32,
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fetch_req,
  input  logic           rti_req,
  input  logic           irq_flag,
  input  logic [IDW-1:0] irq_id,
  input  logic           vbase_we,
  input  logic [DW-1:0]  vbase_wdata,
  input  logic [DW-1:0]  pc_cur,
  input  logic [DW-1:0]  sp_cur,
  input  logic [DW-1:0]  lr_cur,
  output logic           fetch_go,
  output logic           pc_we,
  output logic [DW-1:0]  pc_wdata,
  output logic           sp_we,
  output logic [DW-1:0]  sp_wdata,
  output logic           lr_we,
  output logic [DW-1:0]  lr_wdata,
  output logic           mem_we,
  output logic           mem_re,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           irq_clear,
  output logic           in_handler
);

  localparam int PADW = DW - IDW - 2;

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_VEC} state_t;

  state_t         state;
  logic [IDW-1:0] id_q;
  logic [DW-1:0]  vbase;
  logic           idle, take, ret;

  assign idle = (state == S_IDLE);
  assign ret  = idle && rti_req;
  assign take = idle && fetch_req && !rti_req && irq_flag && !in_handler;

  assign fetch_go  = idle && fetch_req && !rti_req && !take;
  assign irq_clear = ret;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      id_q       <= '0;
      vbase      <= '0;
      in_handler <= 1'b0;
    end else begin
      if (vbase_we) vbase <= vbase_wdata;
      case (state)
        S_IDLE: if (take) begin
          state <= S_PUSH;
          id_q  <= irq_id;
        end else if (ret) begin
          in_handler <= 1'b0;
        end
        S_PUSH: state <= S_VEC;
        S_VEC: begin
          state      <= S_IDLE;
          in_handler <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    pc_we     = 1'b0;
    pc_wdata  = '0;
    sp_we     = 1'b0;
    sp_wdata  = '0;
    lr_we     = 1'b0;
    lr_wdata  = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_PUSH: begin
        sp_we     = 1'b1;
        sp_wdata  = sp_cur - DW'(4);
        mem_we    = 1'b1;
        mem_addr  = sp_cur - DW'(4);
        mem_wdata = lr_cur;
        lr_we     = 1'b1;
        lr_wdata  = pc_cur;
      end
      S_VEC: begin
        mem_re   = 1'b1;
        mem_addr = vbase + {{PADW{1'b0}}, id_q, 2'b00};
        pc_we    = 1'b1;
        pc_wdata = mem_rdata;
      end
      default: if (ret) begin
        pc_we    = 1'b1;
        pc_wdata = lr_cur;
        mem_re   = 1'b1;
        mem_addr = sp_cur;
        lr_we    = 1'b1;
        lr_wdata = mem_rdata;
        sp_we    = 1'b1;
        sp_wdata = sp_cur + DW'(4);
      end
    endcase
  end

  assert_push_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == sp_cur - DW'(4)) && (mem_wdata == lr_cur) && sp_we);

  assert_link_gets_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> lr_we && (lr_wdata == pc_cur));

  assert_vector_follows_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> pc_we && mem_re && !fetch_go);

  assert_no_reentry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_handler && idle && fetch_req && !rti_req) |-> fetch_go);

  assert_return_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear |-> pc_we && (pc_wdata == lr_cur) && (sp_wdata == sp_cur + DW'(4)) && !fetch_go);

  assert_fetch_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> !mem_we && !mem_re && !pc_we);

  assert_take_blocks_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_go && !rti_req && !mem_re && !mem_we) |=> mem_we);

endmodule

// File: tb/irq_vec_seq_tb.sv
module irq_vec_seq_tb;
  localparam int DW  = 32;
  localparam int IDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           fetch_req = 0, rti_req = 0, irq_flag = 0, vbase_we = 0;
  logic [IDW-1:0] irq_id = '0;
  logic [DW-1:0]  vbase_wdata = '0;
  logic [DW-1:0]  pc_r, sp_r, lr_r;
  logic           fetch_go, pc_we, sp_we, lr_we, mem_we, mem_re, irq_clear, in_handler;
  logic [DW-1:0]  pc_wdata, sp_wdata, lr_wdata, mem_addr, mem_wdata, mem_rdata;
  logic [DW-1:0]  mem [64];

  int tests = 0, fails = 0;

  irq_vec_seq #(.DW(DW), .IDW(IDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .rti_req(rti_req),
    .irq_flag(irq_flag), .irq_id(irq_id), .vbase_we(vbase_we), .vbase_wdata(vbase_wdata),
    .pc_cur(pc_r), .sp_cur(sp_r), .lr_cur(lr_r), .fetch_go(fetch_go),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .lr_we(lr_we), .lr_wdata(lr_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq_clear(irq_clear), .in_handler(in_handler));

  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (pc_we)  pc_r <= pc_wdata;
    if (sp_we)  sp_r <= sp_wdata;
    if (lr_we)  lr_r <= lr_wdata;
    if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic entry(input int id, input logic [DW-1:0] base, input bit swap_id);
    logic [DW-1:0] pc0, sp0, lr0;
    pc0 = pc_r; sp0 = sp_r; lr0 = lr_r;
    @(negedge clk); fetch_req = 1; irq_flag = 1; irq_id = IDW'(id); #1;
    chk("R2 fetch_go low on take", {31'b0, fetch_go}, 0);
    @(negedge clk); if (swap_id) irq_id = ~IDW'(id); #1;
    chk("R3 push addr", mem_addr, sp0 - 4);
    chk("R3 push data", mem_wdata, lr0);
    chk("R3 push we", {31'b0, mem_we & sp_we}, 1);
    chk("R4 link value", lr_wdata, pc0);
    chk("R9 fetch held 1", {31'b0, fetch_go}, 0);
    @(negedge clk); #1;
    chk(swap_id ? "R10 table addr" : "R5 table addr", mem_addr, base + 32'(id) * 4);
    chk("R5 pc value", pc_wdata, mem[(base[7:2] + 6'(id))]);
    chk("R9 fetch held 2", {31'b0, fetch_go}, 0);
    @(negedge clk); #1;
    chk("R5 handler pc", pc_r, 32'h1000 + 32'(id) * 16 + (base == 32'h80 ? 32'h800 : 0));
    chk("R3 sp after", sp_r, sp0 - 4);
    chk("R3 stack word", mem[(sp0 - 4) >> 2], lr0);
    chk("R4 r6 after", lr_r, pc0);
    chk("R5 in_handler", {31'b0, in_handler}, 1);
    chk("R6 no re-entry", {31'b0, fetch_go}, 1);
    @(negedge clk); #1;
    chk("R6 pc unchanged", pc_r, 32'h1000 + 32'(id) * 16 + (base == 32'h80 ? 32'h800 : 0));
    fetch_req = 0; irq_flag = 0;
  endtask

  task automatic do_return(input logic [DW-1:0] pc_exp, input logic [DW-1:0] lr_exp,
                           input logic [DW-1:0] sp_exp);
    @(negedge clk); rti_req = 1; #1;
    chk("R7 irq_clear", {31'b0, irq_clear}, 1);
    chk("R7 fetch_go low", {31'b0, fetch_go}, 0);
    @(negedge clk); rti_req = 0; #1;
    chk("R7 pc restored", pc_r, pc_exp);
    chk("R7 r6 restored", lr_r, lr_exp);
    chk("R7 r5 restored", sp_r, sp_exp);
    chk("R7 handler left", {31'b0, in_handler}, 0);
    chk("R7 clear pulse", {31'b0, irq_clear}, 0);
  endtask

  initial begin
    #3_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD0000 + 32'(i);
    for (int i = 0; i < 8; i++) begin
      mem[16 + i] = 32'h1000 + 32'(i) * 16;
      mem[32 + i] = 32'h1800 + 32'(i) * 16;
    end
    pc_r = 32'h200; sp_r = 32'hC0; lr_r = 32'h300;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 in_handler reset", {31'b0, in_handler}, 0);
    chk("R1 no strobes", {28'b0, pc_we, sp_we, lr_we, mem_we}, 0);
    rst_n = 1;
    @(negedge clk); fetch_req = 1; #1;
    chk("R1 fetch_go follows", {31'b0, fetch_go}, 1);
    fetch_req = 0; #1;
    chk("R1 fetch_go idle", {31'b0, fetch_go}, 0);
    vbase_we = 1; vbase_wdata = 32'h40;
    @(negedge clk); vbase_we = 0;

    for (int id = 0; id < 8; id++) begin
      pc_r = 32'h200 + 32'(id) * 8; lr_r = 32'h300 + 32'(id); sp_r = 32'hC0;
      entry(id, 32'h40, 1'b0);
      do_return(32'h200 + 32'(id) * 8, 32'h300 + 32'(id), 32'hC0);
    end

    pc_r = 32'h250; lr_r = 32'h377; sp_r = 32'hB0;
    entry(2, 32'h40, 1'b1);
    do_return(32'h250, 32'h377, 32'hB0);

    @(negedge clk); vbase_we = 1; vbase_wdata = 32'h80;
    @(negedge clk); vbase_we = 0;
    for (int id = 0; id < 8; id += 3) begin
      pc_r = 32'h400 + 32'(id); lr_r = 32'h500 + 32'(id); sp_r = 32'hD0;
      entry(id, 32'h80, 1'b0);
      chk("R8 new base used", pc_r, 32'h1800 + 32'(id) * 16);
      do_return(32'h400 + 32'(id), 32'h500 + 32'(id), 32'hD0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule